// File: doc/BRIEF.md
# Bi-phase Packet Demodulator

The block turns a thresholded HI/LO line, taken from the transmitter's coil current or voltage, into packets. A glitch filter first rejects level changes that are too short to be valid states. A bit slicer then measures the time between the surviving transitions. A transition one bit-period after the previous one yields a zero. Two transitions half a bit-period apart yield a one.

The recovered bit stream passes to a character framer. The framer hunts for a run of ones, called the preamble, that ends in a start bit. It then frames 11-bit characters: a start bit, eight data bits, a parity bit and a stop bit. A packet assembler treats the first character as the header. It derives the message length from the header and presents the message bytes. It then compares the final character with a running XOR and reports whether the packet is good.

Every duration is a parameter counted in clock cycles. `HALF_CYC` is half a bit-period, and `HOLD_CYC` is the minimum state hold time. All outputs are registered, and single-cycle strobes qualify them.

Top module: `bp_packet_demod`

## Requirements
- R1: While reset is high, and in the cycle after it is released, every strobe and error output is low.
- R2: A change of the line level that lasts fewer than `HOLD_CYC` clock cycles is ignored. It neither creates an edge nor disturbs the measured interval.
- R3: An interval between accepted edges of `HALF_CYC-HALF_CYC/4` to `HALF_CYC+HALF_CYC/4` cycles is short. An interval of `2*HALF_CYC-HALF_CYC/2` to `2*HALF_CYC+HALF_CYC/2` cycles is long. Two short intervals form a one, and one long interval forms a zero. Any other interval, or a long interval after an unpaired short one, silently abandons the packet in progress.
- R4: The line may stay still for longer than the long window. After such a silence, the first accepted edge only marks a bit-cell boundary. A silence of that length in the middle of a packet abandons it.
- R5: A packet is recognised only when 11 to 25 consecutive ones are followed by a zero start bit. A run of 10 ones is rejected. A 26th one clears the run count.
- R6: A character is sent as a zero start bit, then data bits least significant first, then a parity bit, then a stop bit. The parity is odd over data and parity. A parity violation pulses `parity_err`. Otherwise, a zero stop bit pulses `stop_err`. In both cases the framer returns to preamble hunting.
- R7: The first character after the preamble is presented once on `hdr_byte`, with `hdr_valid`.
- R8: The number of message bytes follows from header value h as follows. For h below 0x20 it is 1. For h below 0x80 it is 2+(h-0x20)/16. For h below 0xE0 it is 8+(h-0x80)/8. For the remaining headers it is 20+(h-0xE0)/4, rounding down throughout.
- R9: The message bytes are presented in order on `msg_byte`, each with one `msg_valid` pulse.
- R10: The character after the message is the checksum. If it equals the XOR of the header and all message bytes, `pkt_ok` pulses; otherwise `sum_err` pulses.
- R11: After any abandoned or failed packet, the next well-formed packet is decoded in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Thresholded HI/LO modulation line (asynchronous) |
| hdr_valid | output | 1 | Header byte strobe |
| hdr_byte | output | 8 | Header byte |
| msg_valid | output | 1 | Message byte strobe |
| msg_byte | output | 8 | Message byte |
| pkt_ok | output | 1 | Checksum matched, packet complete |
| parity_err | output | 1 | Parity violation in a character |
| stop_err | output | 1 | Stop bit found low |
| sum_err | output | 1 | Checksum mismatch |

## Verification
The bench builds the block with `HALF_CYC=8` and `HOLD_CYC=5`. This gives a short window of 6 to 10 cycles and a long window of 12 to 20 cycles, with an 11-cycle gap between them that aborts a packet. A whole packet of up to 29 characters then takes only a few thousand cycles. Headers are swept across all four length regions, including every region edge. Intervals are driven exactly at both window edges, 4-cycle glitches are driven against the 5-cycle hold, and preambles of 10, 11, 25 and 26 ones are driven. The run also covers every error path and checks recovery after each one.

// File: rtl/bp_demod_pkg.sv
package bp_demod_pkg;

  localparam int unsigned LEN_W = 5;

  typedef enum logic [1:0] {FR_HUNT, FR_BODY, FR_GAP} fr_state_t;
  typedef enum logic [1:0] {PA_IDLE, PA_MSG, PA_SUM} pa_state_t;

  // Message length implied by a header value (1..27 bytes).
  function automatic logic [LEN_W-1:0] msg_len(input logic [7:0] h);
    logic [7:0] t;
    if (h < 8'h20) begin
      return 5'd1;
    end else if (h < 8'h80) begin
      t = h - 8'h20;
      return 5'd2 + {1'b0, t[7:4]};
    end else if (h < 8'hE0) begin
      t = h - 8'h80;
      return 5'd8 + t[7:3];
    end else begin
      t = h - 8'hE0;
      return 5'd20 + t[6:2];
    end
  endfunction

endpackage

// File: rtl/bp_glitch_filter.sv
module bp_glitch_filter #(
  parameter int HOLD_CYC = 7500
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic edge_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          s1, s2, lvl;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      lvl    <= 1'b0;
      cnt    <= '0;
      edge_o <= 1'b0;
    end else begin
      s1     <= line_i;
      s2     <= s1;
      edge_o <= 1'b0;
      if (s2 == lvl) begin
        cnt <= '0;
      end else if (cnt == CW'(HOLD_CYC - 1)) begin
        lvl    <= s2;
        cnt    <= '0;
        edge_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // The filtered level only ever moves to the value the synchronised line held.
  assert_level_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lvl)) |-> (lvl == $past(s2)));

  // An accepted change needs the line to differ from the level in the prior cycle too.
  assert_no_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (edge_o && HOLD_CYC > 1) |-> ($past(s2) != $past(lvl)));

endmodule

// File: rtl/bp_bit_slicer.sv
module bp_bit_slicer #(
  parameter int HALF_CYC = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic bit_v,
  output logic bit_d,
  output logic abort
);
  localparam int SHORT_MIN = HALF_CYC - HALF_CYC / 4;
  localparam int SHORT_MAX = HALF_CYC + HALF_CYC / 4;
  localparam int LONG_MIN  = 2 * HALF_CYC - HALF_CYC / 2;
  localparam int LONG_MAX  = 2 * HALF_CYC + HALF_CYC / 2;
  localparam int IW        = $clog2(LONG_MAX + 2);

  logic [IW-1:0] iv;
  logic          synced, pend;
  logic          is_short, is_long, silent;

  always_comb begin
    is_short = (iv >= IW'(SHORT_MIN)) && (iv <= IW'(SHORT_MAX));
    is_long  = (iv >= IW'(LONG_MIN))  && (iv <= IW'(LONG_MAX));
    silent   = (iv > IW'(LONG_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iv     <= '0;
      synced <= 1'b0;
      pend   <= 1'b0;
      bit_v  <= 1'b0;
      bit_d  <= 1'b0;
      abort  <= 1'b0;
    end else begin
      bit_v <= 1'b0;
      abort <= 1'b0;
      if (!silent) iv <= iv + 1'b1;
      if (edge_i) begin
        iv <= IW'(1);
        if (!synced) begin
          synced <= 1'b1;
          pend   <= 1'b0;
        end else if (is_short) begin
          if (pend) begin
            bit_v <= 1'b1;
            bit_d <= 1'b1;
            pend  <= 1'b0;
          end else begin
            pend <= 1'b1;
          end
        end else if (is_long && !pend) begin
          bit_v <= 1'b1;
          bit_d <= 1'b0;
        end else begin
          abort  <= 1'b1;
          synced <= 1'b0;
          pend   <= 1'b0;
        end
      end else if (synced && silent) begin
        abort  <= 1'b1;
        synced <= 1'b0;
        pend   <= 1'b0;
      end
    end
  end

  assert_bit_needs_edge_R3: assert property (@(posedge clk) disable iff (rst)
    bit_v |-> $past(edge_i));

  assert_one_needs_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (bit_v && bit_d) |-> $past(pend));

  assert_bit_abort_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(bit_v && abort));

  assert_silence_abort_R4: assert property (@(posedge clk) disable iff (rst)
    (abort && !$past(edge_i)) |-> ($past(iv) == IW'(LONG_MAX + 1)));

endmodule

// File: rtl/bp_byte_framer.sv
module bp_byte_framer
  import bp_demod_pkg::*;
#(
  parameter int PRE_MIN = 11,
  parameter int PRE_MAX = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_v,
  input  logic       bit_d,
  input  logic       abort,
  output logic       byte_v,
  output logic [7:0] byte_d,
  output logic       byte_first,
  output logic       par_err,
  output logic       stop_err
);
  localparam int PW = $clog2(PRE_MAX + 1);

  fr_state_t     st;
  logic [PW-1:0] pre_cnt;
  logic [3:0]    bcnt;
  logic [7:0]    sh;
  logic          par, first_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= FR_HUNT;
      pre_cnt    <= '0;
      bcnt       <= '0;
      sh         <= '0;
      par        <= 1'b0;
      first_pend <= 1'b0;
      byte_v     <= 1'b0;
      byte_d     <= '0;
      byte_first <= 1'b0;
      par_err    <= 1'b0;
      stop_err   <= 1'b0;
    end else begin
      byte_v   <= 1'b0;
      par_err  <= 1'b0;
      stop_err <= 1'b0;
      if (abort) begin
        st      <= FR_HUNT;
        pre_cnt <= '0;
      end else if (bit_v) begin
        case (st)
          FR_HUNT: begin
            if (bit_d) begin
              pre_cnt <= (pre_cnt < PW'(PRE_MAX)) ? pre_cnt + 1'b1 : '0;
            end else begin
              if (pre_cnt >= PW'(PRE_MIN)) begin
                st         <= FR_BODY;
                bcnt       <= '0;
                first_pend <= 1'b1;
              end
              pre_cnt <= '0;
            end
          end
          FR_BODY: begin
            if (bcnt < 4'd8) begin
              sh[bcnt[2:0]] <= bit_d;
              bcnt          <= bcnt + 1'b1;
            end else if (bcnt == 4'd8) begin
              par  <= bit_d;
              bcnt <= bcnt + 1'b1;
            end else begin
              if (^{sh, par} == 1'b0) begin
                par_err <= 1'b1;
                st      <= FR_HUNT;
              end else if (!bit_d) begin
                stop_err <= 1'b1;
                st       <= FR_HUNT;
              end else begin
                byte_v     <= 1'b1;
                byte_d     <= sh;
                byte_first <= first_pend;
                first_pend <= 1'b0;
                st         <= FR_GAP;
              end
            end
          end
          FR_GAP: begin
            if (!bit_d) begin
              st   <= FR_BODY;
              bcnt <= '0;
            end else begin
              st      <= FR_HUNT;
              pre_cnt <= PW'(1);
            end
          end
          default: st <= FR_HUNT;
        endcase
      end
    end
  end

  assert_outcome_from_body_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_v || par_err || stop_err) |-> ($past(bit_v) && $past(st) == FR_BODY));

  assert_single_outcome_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({byte_v, par_err, stop_err}));

  assert_run_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PW'(PRE_MAX));

endmodule

// File: rtl/bp_packet_asm.sv
module bp_packet_asm
  import bp_demod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_v,
  input  logic [7:0] byte_d,
  input  logic       byte_first,
  input  logic       drop,
  output logic       hdr_v,
  output logic [7:0] hdr_d,
  output logic       msg_v,
  output logic [7:0] msg_d,
  output logic       pkt_ok,
  output logic       sum_err
);
  pa_state_t        st;
  logic [LEN_W-1:0] rem;
  logic [7:0]       acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PA_IDLE;
      rem     <= '0;
      acc     <= '0;
      hdr_v   <= 1'b0;
      hdr_d   <= '0;
      msg_v   <= 1'b0;
      msg_d   <= '0;
      pkt_ok  <= 1'b0;
      sum_err <= 1'b0;
    end else begin
      hdr_v   <= 1'b0;
      msg_v   <= 1'b0;
      pkt_ok  <= 1'b0;
      sum_err <= 1'b0;
      if (drop) begin
        st <= PA_IDLE;
      end else if (byte_v) begin
        if (byte_first) begin
          hdr_v <= 1'b1;
          hdr_d <= byte_d;
          acc   <= byte_d;
          rem   <= msg_len(byte_d);
          st    <= PA_MSG;
        end else begin
          case (st)
            PA_MSG: begin
              msg_v <= 1'b1;
              msg_d <= byte_d;
              acc   <= acc ^ byte_d;
              rem   <= rem - 1'b1;
              if (rem == LEN_W'(1)) st <= PA_SUM;
            end
            PA_SUM: begin
              if (byte_d == acc) pkt_ok <= 1'b1;
              else               sum_err <= 1'b1;
              st <= PA_IDLE;
            end
            default: st <= PA_IDLE;
          endcase
        end
      end
    end
  end

  assert_hdr_from_first_R7: assert property (@(posedge clk) disable iff (rst)
    hdr_v |-> $past(byte_v && byte_first));

  assert_rem_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    (st == PA_MSG) |-> (rem != '0));

  assert_msg_in_body_R9: assert property (@(posedge clk) disable iff (rst)
    msg_v |-> ($past(st) == PA_MSG));

  assert_verdict_on_sum_R10: assert property (@(posedge clk) disable iff (rst)
    (pkt_ok || sum_err) |-> ($past(st) == PA_SUM && $past(byte_v)));

endmodule

// File: rtl/bp_packet_demod.sv
module bp_packet_demod #(
  parameter int HALF_CYC = 12500,
  parameter int HOLD_CYC = 7500,
  parameter int PRE_MIN  = 11,
  parameter int PRE_MAX  = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_i,
  output logic       hdr_valid,
  output logic [7:0] hdr_byte,
  output logic       msg_valid,
  output logic [7:0] msg_byte,
  output logic       pkt_ok,
  output logic       parity_err,
  output logic       stop_err,
  output logic       sum_err
);
  logic       edge_w, bit_v, bit_d, abort;
  logic       byte_v, byte_first, par_e, stop_e;
  logic [7:0] byte_d;

  bp_glitch_filter #(.HOLD_CYC(HOLD_CYC)) u_filt (
    .clk(clk), .rst(rst), .line_i(line_i), .edge_o(edge_w)
  );

  bp_bit_slicer #(.HALF_CYC(HALF_CYC)) u_slice (
    .clk(clk), .rst(rst), .edge_i(edge_w),
    .bit_v(bit_v), .bit_d(bit_d), .abort(abort)
  );

  bp_byte_framer #(.PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX)) u_frame (
    .clk(clk), .rst(rst), .bit_v(bit_v), .bit_d(bit_d), .abort(abort),
    .byte_v(byte_v), .byte_d(byte_d), .byte_first(byte_first),
    .par_err(par_e), .stop_err(stop_e)
  );

  bp_packet_asm u_asm (
    .clk(clk), .rst(rst), .byte_v(byte_v), .byte_d(byte_d),
    .byte_first(byte_first), .drop(abort | par_e | stop_e),
    .hdr_v(hdr_valid), .hdr_d(hdr_byte), .msg_v(msg_valid), .msg_d(msg_byte),
    .pkt_ok(pkt_ok), .sum_err(sum_err)
  );

  assign parity_err = par_e;
  assign stop_err   = stop_e;

endmodule

// File: tb/tb_bp_packet_demod.sv
module tb_bp_packet_demod;
  localparam int HALF = 8;
  localparam int HOLD = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line = 1'b0;
  logic       hdr_valid, msg_valid, pkt_ok, parity_err, stop_err, sum_err;
  logic [7:0] hdr_byte, msg_byte;

  always #5 clk = ~clk;

  bp_packet_demod #(.HALF_CYC(HALF), .HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst(rst), .line_i(line),
    .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
    .msg_valid(msg_valid), .msg_byte(msg_byte),
    .pkt_ok(pkt_ok), .parity_err(parity_err),
    .stop_err(stop_err), .sum_err(sum_err)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int n_hdr = 0, n_msg = 0, n_ok = 0, n_par = 0, n_stop = 0, n_sum = 0;
  logic [7:0] last_hdr = 8'h00;
  logic [7:0] cap [0:63];
  int b_hdr, b_msg, b_ok, b_par, b_stop, b_sum;

  logic [7:0] pay [0:31];
  bit jit_mode = 1'b0, jit_flip = 1'b0, glitch_mode = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (hdr_valid) begin n_hdr++; last_hdr = hdr_byte; end
      if (msg_valid) begin cap[n_msg % 64] = msg_byte; n_msg++; end
      if (pkt_ok)     n_ok++;
      if (parity_err) n_par++;
      if (stop_err)   n_stop++;
      if (sum_err)    n_sum++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dur_short(output int d);
    if (jit_mode) begin d = jit_flip ? 10 : 6; jit_flip = !jit_flip; end
    else d = HALF;
  endtask

  task automatic dur_long(output int d);
    if (jit_mode) begin d = jit_flip ? 20 : 12; jit_flip = !jit_flip; end
    else d = 2 * HALF;
  endtask

  task automatic send_bit(input logic b);
    int d;
    if (b) begin
      dur_short(d); wait_cyc(d); line = ~line;
      dur_short(d); wait_cyc(d); line = ~line;
    end else begin
      dur_long(d);
      if (glitch_mode && d >= 16) begin
        wait_cyc(5); line = ~line; wait_cyc(HOLD - 1); line = ~line;
        wait_cyc(d - 5 - (HOLD - 1));
      end else begin
        wait_cyc(d);
      end
      line = ~line;
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit par_bad, input bit stop_bad);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit((~^d) ^ par_bad);
    send_bit(!stop_bad);
  endtask

  task automatic send_packet(input logic [7:0] hdr, input int npay, input int pre,
                             input logic [7:0] sum_flip, input bit par_bad,
                             input bit stop_bad, input bit bad_iv);
    logic [7:0] acc;
    line = ~line;
    repeat (pre) send_bit(1'b1);
    send_byte(hdr, 1'b0, 1'b0);
    acc = hdr;
    if (bad_iv) begin wait_cyc(11); line = ~line; end
    for (int i = 0; i < npay; i++) begin
      send_byte(pay[i], 1'b0, 1'b0);
      acc = acc ^ pay[i];
    end
    send_byte(acc ^ sum_flip, par_bad, stop_bad);
    wait_cyc(60);
  endtask

  function automatic int exp_len(input int h);
    if (h < 32)  return 1;
    if (h < 128) return 2 + (h - 32) / 16;
    if (h < 224) return 8 + (h - 128) / 8;
    return 20 + (h - 224) / 4;
  endfunction

  task automatic snap();
    b_hdr = n_hdr; b_msg = n_msg; b_ok = n_ok;
    b_par = n_par; b_stop = n_stop; b_sum = n_sum;
  endtask

  task automatic fill(input int hdr);
    for (int i = 0; i < 32; i++) pay[i] = 8'((hdr * 3 + i * 29 + 1) & 255);
  endtask

  task automatic good_packet(input int hdr, input int pre, input string req);
    int len, bad;
    len = exp_len(hdr);
    fill(hdr);
    snap();
    send_packet(8'(hdr), len, pre, 8'h00, 1'b0, 1'b0, 1'b0);
    chk(n_hdr - b_hdr == 1, req, "R7 header count", n_hdr - b_hdr, 1);
    chk(last_hdr == 8'(hdr), req, "R7 header value", last_hdr, hdr);
    chk(n_msg - b_msg == len, req, "R8 message length", n_msg - b_msg, len);
    bad = 0;
    for (int i = 0; i < len; i++) if (cap[(b_msg + i) % 64] != pay[i]) bad++;
    chk(bad == 0, req, "R9 message byte mismatches", bad, 0);
    chk(n_ok - b_ok == 1, req, "R10 pkt_ok count", n_ok - b_ok, 1);
    chk((n_par - b_par) + (n_stop - b_stop) + (n_sum - b_sum) == 0, req, "R6 R10 error count",
        (n_par - b_par) + (n_stop - b_stop) + (n_sum - b_sum), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    chk({hdr_valid, msg_valid, pkt_ok, parity_err, stop_err, sum_err} == 6'b0,
        "R1", "strobes in reset", {hdr_valid, msg_valid, pkt_ok, parity_err, stop_err, sum_err}, 0);
    rst = 1'b0;
    wait_cyc(1);
    chk({hdr_valid, msg_valid, pkt_ok, parity_err, stop_err, sum_err} == 6'b0,
        "R1", "strobes after release", {hdr_valid, msg_valid, pkt_ok, parity_err, stop_err, sum_err}, 0);
    wait_cyc(30);

    // R8 region edges, R5 preamble of 11 and 25
    begin
      int hl [10] = '{8'h00, 8'h1F, 8'h20, 8'h7F, 8'h80, 8'hDF, 8'hE0, 8'hFF, 8'h45, 8'hA3};
      for (int k = 0; k < 10; k++) good_packet(hl[k], (k % 2) ? 25 : 11, "R5 R8");
    end
    for (int h = 3; h < 256; h += 23) good_packet(h, 11 + (h % 15), "R8 sweep");

    // R3 window edges: shorts of 6/10, longs of 12/20
    jit_mode = 1'b1;
    good_packet(8'h30, 12, "R3 window edges");
    jit_mode = 1'b0;

    // R2 glitches of HOLD-1 cycles inside every long interval
    glitch_mode = 1'b1;
    good_packet(8'h25, 13, "R2 glitches");
    glitch_mode = 1'b0;

    // R2 glitch on an idle line
    snap();
    line = ~line; wait_cyc(HOLD - 1); line = ~line; wait_cyc(60);
    good_packet(8'h05, 11, "R2 R4 after idle glitch");

    // R5 preamble too short / too long
    pay[0] = 8'h11;
    snap();
    send_packet(8'h05, 1, 10, 8'h00, 1'b0, 1'b0, 1'b0);
    chk(n_hdr - b_hdr == 0, "R5", "header after 10 ones", n_hdr - b_hdr, 0);
    snap();
    send_packet(8'h05, 1, 26, 8'h00, 1'b0, 1'b0, 1'b0);
    chk(n_hdr - b_hdr == 0, "R5", "header after 26 ones", n_hdr - b_hdr, 0);

    // R6 parity, stop, and precedence on the checksum character
    pay[0] = 8'h11;
    snap();
    send_packet(8'h05, 1, 11, 8'h00, 1'b1, 1'b0, 1'b0);
    chk(n_par - b_par == 1, "R6", "parity_err count", n_par - b_par, 1);
    chk(n_ok - b_ok == 0, "R6", "pkt_ok on parity fault", n_ok - b_ok, 0);
    snap();
    send_packet(8'h05, 1, 11, 8'h00, 1'b0, 1'b1, 1'b0);
    chk(n_stop - b_stop == 1, "R6", "stop_err count", n_stop - b_stop, 1);
    chk(n_ok - b_ok == 0, "R6", "pkt_ok on stop fault", n_ok - b_ok, 0);
    snap();
    send_packet(8'h05, 1, 11, 8'h00, 1'b1, 1'b1, 1'b0);
    chk(n_par - b_par == 1 && n_stop - b_stop == 0, "R6", "precedence parity over stop",
        (n_par - b_par) * 10 + (n_stop - b_stop), 10);

    // R10 wrong checksum
    snap();
    send_packet(8'h05, 1, 11, 8'h40, 1'b0, 1'b0, 1'b0);
    chk(n_sum - b_sum == 1, "R10", "sum_err count", n_sum - b_sum, 1);
    chk(n_ok - b_ok == 0, "R10", "pkt_ok on bad checksum", n_ok - b_ok, 0);

    // R3 out-of-window interval, then R11 recovery
    snap();
    send_packet(8'h05, 1, 11, 8'h00, 1'b0, 1'b0, 1'b1);
    chk(n_hdr - b_hdr == 1 && n_msg - b_msg == 0, "R3", "bytes after 11-cycle interval",
        n_msg - b_msg, 0);
    chk(n_ok - b_ok == 0 && (n_par - b_par) + (n_stop - b_stop) + (n_sum - b_sum) == 0,
        "R3", "silent abort outcome", n_ok - b_ok, 0);
    good_packet(8'h9C, 11, "R11 recovery");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule